// File: doc/BRIEF.md
# Folded Memory Array Address Decoder

This block models a word-addressed memory whose logical shape, 2^n words of 2^m bits, is stored as a shorter and wider physical array. The array is folded by 2^k, so it has 2^(n-k) rows and 2^(m+k) columns. An n-bit word address is split into two parts. The high part picks one physical row through a two-level predecoded row decoder. The low part steers a bank of 2^k:1 tree multiplexers, one per data bit, which pick the addressed word out of the wide row.

Each cycle the block performs at most one access: a read or a write. Read data is captured in an output register and appears one cycle after the request. A write changes only the columns that belong to the addressed word. The decoded wordlines are brought out as a port so that the row decode can be watched directly. The defaults are 128 words of 8 bits folded by 4 into 32 rows of 32 columns. With these defaults the 5-bit row address has an odd width, so the last predecoder decodes a single bit.

Top module: `fold_mem_decoder`

## Requirements
- R1: The row index is `addr[ADDR_W-1:FOLD_LOG]` and the column group is `addr[FOLD_LOG-1:0]`. While `req` is high, `wordline[row index]` is 1 in the same cycle.
- R2: While `req` is high exactly one bit of `wordline` is set. While `req` is low, `wordline` is all zeros.
- R3: Row bits are predecoded in pairs into 1-of-4 lines, and an odd leftover bit goes into 1-of-2 lines. Every row value from 0 to ROWS-1, including the rows whose top bit falls in the single-bit predecoder, raises only its own wordline.
- R4: A write (`req`=1, `we`=1) updates only the word at the addressed column group. The other words stored in the same row keep their values.
- R5: A read (`req`=1, `we`=0) presented before a rising edge puts the stored word on `rdata` and sets `rvalid` to 1 after that edge.
- R6: After an edge with no read (`req`=0, or a write), `rvalid` is 0 and `rdata` keeps its previous value.
- R7: While reset is applied, and after it, until the first read, `rdata` is 0 and `rvalid` is 0.
- R8: A read returns the value of the most recent write to that address, including a read issued in the cycle right after the write.
- R9: A cycle with `req`=1 and `we`=1 only writes. It produces no read result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Access request for this cycle |
| we | input | 1 | 1 = write, 0 = read, qualified by `req` |
| addr | input | ADDR_W | Word address: high bits pick the row, low FOLD_LOG bits pick the column group |
| wdata | input | 2**WORD_LOG | Write data |
| wordline | output | 2**(ADDR_W-FOLD_LOG) | One-hot decoded row select |
| rdata | output | 2**WORD_LOG | Registered read data |
| rvalid | output | 1 | High for one cycle after each read |

## Verification
The bench steps the address through all 128 words, so that every wordline is driven, including the upper half that depends on the one-bit predecoder. If that predecoder were mis-sized or mis-indexed, the wrong row or two rows would be raised. Directed writes fill every word of one row and then overwrite one of them. A design that writes the whole row instead of a single column group would corrupt the neighbouring words. Back-to-back write-then-read sequences on one address expose a read that returns stale data or comes out a cycle early or late. Idle and write cycles placed between reads show whether `rdata` drifts when there is no read or `rvalid` stays set.

// File: rtl/fold_mem_pkg.sv
package fold_mem_pkg;
  // number of predecoder groups needed for a row address of the given width
  function automatic int predec_groups(input int row_bits);
    return (row_bits + 1) / 2;
  endfunction

  // width of the address slice handled by predecoder group g
  function automatic int predec_width(input int row_bits, input int g);
    return ((row_bits - 2 * g) >= 2) ? 2 : 1;
  endfunction
endpackage

// File: rtl/fmd_rst_sync.sv
module fmd_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) stage_q <= 2'b00;
    else           stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_out = stage_q[1];
endmodule

// File: rtl/fmd_predecoder.sv
module fmd_predecoder #(
  parameter int BITS = 2
) (
  input  logic [BITS-1:0]    sel,
  output logic [2**BITS-1:0] hot
);
  localparam int LINES = 2 ** BITS;

  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      hot[i] = (sel == BITS'(i));
    end
  end
endmodule

// File: rtl/fmd_row_decoder.sv
module fmd_row_decoder
  import fold_mem_pkg::*;
#(
  parameter int ROW_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [ROW_W-1:0]    row_addr,
  output logic [2**ROW_W-1:0] wl
);
  localparam int ROWS   = 2 ** ROW_W;
  localparam int GROUPS = predec_groups(ROW_W);

  logic [3:0] pre [GROUPS];

  for (genvar g = 0; g < GROUPS; g++) begin : g_pre
    localparam int GW = predec_width(ROW_W, g);
    logic [2**GW-1:0] lines;
    fmd_predecoder #(.BITS(GW)) u_pre (
      .sel (row_addr[2*g +: GW]),
      .hot (lines)
    );
    if (GW == 2) begin : g_quad
      assign pre[g] = lines;
    end else begin : g_pair
      assign pre[g] = {2'b00, lines};
    end
  end

  // final wordline: AND of one line from every predecoder, gated by the request
  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      logic hit;
      hit = en;
      for (int g = 0; g < GROUPS; g++) begin
        hit = hit & pre[g][(r >> (2 * g)) & 3];
      end
      wl[r] = hit;
    end
  end

  assert_wl_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> wl[row_addr]);

  assert_wl_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ($countones(wl) == 1));

  assert_wl_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (wl == '0));
endmodule

// File: rtl/fmd_col_mux.sv
module fmd_col_mux #(
  parameter int SEL_W = 2
) (
  input  logic [2**SEL_W-1:0] din,
  input  logic [SEL_W-1:0]    sel,
  output logic                dout
);
  localparam int IN_W = 2 ** SEL_W;

  // binary tree, level l steered directly by address bit l
  for (genvar l = 0; l < SEL_W; l++) begin : g_lvl
    localparam int NW = IN_W >> (l + 1);
    logic [NW-1:0] node;
    for (genvar j = 0; j < NW; j++) begin : g_node
      if (l == 0) begin : g_leaf
        assign node[j] = sel[0] ? din[2*j+1] : din[2*j];
      end else begin : g_inner
        assign node[j] = sel[l] ? g_lvl[l-1].node[2*j+1] : g_lvl[l-1].node[2*j];
      end
    end
  end

  assign dout = g_lvl[SEL_W-1].node[0];
endmodule

// File: rtl/fold_mem_decoder.sv
module fold_mem_decoder #(
  parameter int ADDR_W   = 7,
  parameter int WORD_LOG = 3,
  parameter int FOLD_LOG = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [2**WORD_LOG-1:0]        wdata,
  output logic [2**(ADDR_W-FOLD_LOG)-1:0] wordline,
  output logic [2**WORD_LOG-1:0]        rdata,
  output logic                          rvalid
);
  localparam int WORD_W = 2 ** WORD_LOG;
  localparam int ROW_W  = ADDR_W - FOLD_LOG;
  localparam int ROWS   = 2 ** ROW_W;
  localparam int GROUP  = 2 ** FOLD_LOG;
  localparam int COLS   = WORD_W * GROUP;

  logic                rst_q_n;
  logic [ROW_W-1:0]    row_addr;
  logic [FOLD_LOG-1:0] col_addr;
  logic [COLS-1:0]     mem [ROWS];
  logic [COLS-1:0]     row_bits;
  logic [COLS-1:0]     col_wen;
  logic [COLS-1:0]     wide_wdata;
  logic [WORD_W-1:0]   rd_word;
  logic                rd_en;
  logic                wr_en;
  logic [WORD_W-1:0]   rdata_d, rdata_q;
  logic                rvalid_d, rvalid_q;

  fmd_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_q_n)
  );

  assign row_addr = addr[ADDR_W-1:FOLD_LOG];
  assign col_addr = addr[FOLD_LOG-1:0];
  assign rd_en    = req & ~we;
  assign wr_en    = req & we;

  fmd_row_decoder #(.ROW_W(ROW_W)) u_rowdec (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .en       (req),
    .row_addr (row_addr),
    .wl       (wordline)
  );

  // physical column b*GROUP+c holds bit b of the word in column group c
  for (genvar j = 0; j < COLS; j++) begin : g_col
    assign col_wen[j]    = (FOLD_LOG'(j % GROUP) == col_addr);
    assign wide_wdata[j] = wdata[j / GROUP];
  end

  // wordline-selected row onto the shared bitlines
  always_comb begin
    row_bits = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (wordline[r]) row_bits = row_bits | mem[r];
    end
  end

  for (genvar b = 0; b < WORD_W; b++) begin : g_mux
    fmd_col_mux #(.SEL_W(FOLD_LOG)) u_mux (
      .din  (row_bits[b*GROUP +: GROUP]),
      .sel  (col_addr),
      .dout (rd_word[b])
    );
  end

  // storage: no reset, write enable per row and per column group
  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++) begin
      if (wr_en && wordline[r]) begin
        mem[r] <= (mem[r] & ~col_wen) | (wide_wdata & col_wen);
      end
    end
  end

  always_comb begin
    rdata_d  = rdata_q;
    rvalid_d = 1'b0;
    if (rd_en) begin
      rdata_d  = rd_word;
      rvalid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  assert_rd_latency_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req && !we) |=> rvalid);

  assert_no_read_hold_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(req && !we) |=> ($stable(rdata) && !rvalid));

  assert_write_only_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req && we) |=> !rvalid);

  assert_wr_then_rd_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req && !we && $past(req && we) && (addr == $past(addr)))
      |=> (rdata == $past(wdata, 2)));
endmodule

// File: tb/sim_fold_mem_decoder.sv
module sim_fold_mem_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W   = 7;
  localparam int WORD_LOG = 3;
  localparam int FOLD_LOG = 2;
  localparam int WORD_W   = 2 ** WORD_LOG;
  localparam int ROW_W    = ADDR_W - FOLD_LOG;
  localparam int ROWS     = 2 ** ROW_W;
  localparam int WORDS    = 2 ** ADDR_W;
  localparam int WATCHDOG = 100000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req;
  logic              we;
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] wdata;
  logic [ROWS-1:0]   wordline;
  logic [WORD_W-1:0] rdata;
  logic              rvalid;

  int checks = 0;
  int errors = 0;
  logic [WORD_W-1:0] model [WORDS];
  logic [WORD_W-1:0] exp_rdata;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fold_mem_decoder #(.ADDR_W(ADDR_W), .WORD_LOG(WORD_LOG), .FOLD_LOG(FOLD_LOG)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .wordline(wordline), .rdata(rdata), .rvalid(rvalid)
  );

  function automatic logic [ROWS-1:0] exp_wl(input logic r, input logic [ADDR_W-1:0] a);
    logic [ROWS-1:0] v;
    v = '0;
    if (r) v[a >> FOLD_LOG] = 1'b1;
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one access cycle: drive at falling edge, check decode, then registered outputs
  task automatic access(input logic r, input logic w, input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d);
    logic [ROWS-1:0] ew;
    @(negedge clk);
    req = r; we = w; addr = a; wdata = d;
    #1;
    ew = exp_wl(r, a);
    check(wordline === ew, r ? "R1/R3 wordline" : "R2 idle wordline", 64'(wordline), 64'(ew));
    if (r) check($countones(wordline) == 1, "R2 one-hot", 64'($countones(wordline)), 64'd1);
    @(posedge clk);
    #1;
    if (r && !w) begin
      exp_rdata = model[a];
      check(rvalid === 1'b1, "R5 rvalid", 64'(rvalid), 64'd1);
      check(rdata === exp_rdata, "R8 rdata", 64'(rdata), 64'(exp_rdata));
    end else begin
      check(rvalid === 1'b0, w ? "R9 rvalid on write" : "R6 rvalid idle", 64'(rvalid), 64'd0);
      check(rdata === exp_rdata, "R6 rdata hold", 64'(rdata), 64'(exp_rdata));
      if (r && w) model[a] = d;
    end
  endtask

  initial begin : watchdog
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        checks++;
        errors++;
        $display("FAIL watchdog R5 actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_0017);
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    exp_rdata = '0;
    repeat (3) @(posedge clk);
    #1;
    check(rdata === '0, "R7 reset rdata", 64'(rdata), 64'd0);
    check(rvalid === 1'b0, "R7 reset rvalid", 64'(rvalid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) access(1'b0, 1'b0, '0, '0);
    check(rdata === '0, "R7 post-reset rdata", 64'(rdata), 64'd0);

    // fill every word in address order: every wordline, both predecoder kinds (R3)
    for (int i = 0; i < WORDS; i++) begin
      access(1'b1, 1'b1, ADDR_W'(i), WORD_W'(i * 37 + 11));
    end
    for (int i = 0; i < WORDS; i++) begin
      access(1'b1, 1'b0, ADDR_W'(i), '0);
    end

    // R4: overwrite one word of a row, neighbours keep values (low and top rows)
    for (int base = 'h24; base <= 'h7c; base += 'h58) begin
      for (int c = 0; c < 4; c++) access(1'b1, 1'b1, ADDR_W'(base + c), WORD_W'(8'hA0 + c));
      access(1'b1, 1'b1, ADDR_W'(base + 1), 8'h5C);
      for (int c = 0; c < 4; c++) access(1'b1, 1'b0, ADDR_W'(base + c), '0);
    end

    // R8: read the cycle right after a write to the same address
    access(1'b1, 1'b1, 7'h7f, 8'hFF);
    access(1'b1, 1'b0, 7'h7f, '0);
    access(1'b1, 1'b1, 7'h00, 8'h00);
    access(1'b1, 1'b0, 7'h00, '0);
    // R6/R9: write then idle after a read leave rdata untouched
    access(1'b1, 1'b0, 7'h25, '0);
    access(1'b1, 1'b1, 7'h26, 8'h33);
    access(1'b0, 1'b1, 7'h27, 8'h44);

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic r, w;
      r = ($urandom % 10) != 0;
      w = ($urandom % 2) == 1;
      access(r, w, ADDR_W'($urandom), WORD_W'($urandom));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule